// File: doc/BRIEF.md
# Signed-Count Arithmetic Barrel Shifter

This block shifts a 32-bit operand by a signed distance taken from a count word. Only the low seven bits of the count word matter. They form a two's-complement number from -64 to +63. The sign of that number picks the direction: a positive value shifts left with zeros entering at the bottom, and a negative value shifts right with copies of the sign bit entering at the top. The bit that leaves the word last is reported as a carry, alongside negative and zero status of the result.

The block sits in a datapath as a single registered stage. The caller presents an operand and a count word with `in_valid` high. One clock later the result, carry and both flags appear with `out_valid` high. A count of zero passes the operand through and keeps the carry from the previous operation. Distances of 32 or more saturate: the result is all zeros on a left shift and all sign copies on a right shift.

Top module: `signed_count_shifter`

## Requirements
- R1: Only bits [6:0] of `in_count` are used, as a two's-complement distance; bits [31:7] have no effect on any output.
- R2: For a positive count n, `out_result` equals the operand shifted left by n with zeros entering at bit 0.
- R3: For a positive count n, `out_carry` equals operand bit 32-n when n is 32 or less, and 0 when n is above 32.
- R4: For a negative count -m, `out_result` equals the operand shifted right by m with copies of operand bit 31 entering at the top.
- R5: For a negative count -m, `out_carry` equals operand bit m-1 when m is 32 or less, and operand bit 31 when m is above 32.
- R6: A left distance of 32 or more gives an all-zero result, and a right distance of 32 or more gives a result in which every bit equals operand bit 31.
- R7: A count of zero gives `out_result` equal to the operand and leaves `out_carry` at its previous registered value.
- R8: `out_neg` equals bit 31 of `out_result`, and `out_zero` is 1 exactly when all 32 bits of `out_result` are 0.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise; while `in_valid` is low the other outputs hold their values.
- R10: While `rst` is high at a clock edge, every output, including `out_valid`, is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and count are presented this cycle |
| in_operand | input | 32 | Word to be shifted |
| in_count | input | 32 | Count word; the low 7 bits hold the signed distance |
| out_valid | output | 1 | Registered outputs hold a new result |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | Last bit shifted out |
| out_neg | output | 1 | Bit 31 of the result |
| out_zero | output | 1 | Result is all zeros |

## Verification
Random operands are paired with counts drawn over the full -64..+63 range. This exercises both directions and every distance, and it separates a sign fill from a zero fill whenever operand bit 31 is set. Directed counts of ±1, ±31, ±32, +33, -33, +63 and -64 sit on both sides of the saturation edge. They show whether the carry is taken from the right bit position, or taken at all, once the whole word has left. A zero count that follows shifts with carry 1 and then carry 0 shows that the carry is held rather than cleared. Count words whose upper bits are set, and idle cycles between operations, show that neither the discarded bits nor an absent `in_valid` disturbs the outputs.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int DEF_DATA_W    = 32;
  localparam int DEF_CNT_BITS  = 7;
  localparam int DEF_CNT_REG_W = 32;

  typedef enum logic [1:0] {
    DIR_HOLD  = 2'd0,
    DIR_LEFT  = 2'd1,
    DIR_RIGHT = 2'd2
  } shift_dir_e;
endpackage

// File: rtl/scs_count_decode.sv
module scs_count_decode
  import scs_pkg::*;
#(
  parameter int CNT_BITS = DEF_CNT_BITS
) (
  input  logic [CNT_BITS-1:0] cnt,
  output shift_dir_e          dir,
  output logic [CNT_BITS-1:0] mag
);
  localparam logic [CNT_BITS-1:0] MAX_POS = {1'b0, {(CNT_BITS-1){1'b1}}};

  logic neg;
  assign neg = cnt[CNT_BITS-1];

  // Two's-complement magnitude; the most negative value maps to 2^(CNT_BITS-1).
  assign mag = neg ? (~cnt + 1'b1) : cnt;

  always_comb begin
    if (cnt == '0)  dir = DIR_HOLD;
    else if (neg)   dir = DIR_RIGHT;
    else            dir = DIR_LEFT;
  end

  always_comb begin
    assert_dir_mag_R1 : assert ((dir == DIR_HOLD) == (mag == '0));
    if (dir == DIR_LEFT)
      assert_left_range_R1 : assert (mag <= MAX_POS);
  end
endmodule

// File: rtl/scs_barrel.sv
module scs_barrel #(
  parameter int XW   = 33,
  parameter int AW   = 7,
  parameter bit LEFT = 1'b1
) (
  input  logic [XW-1:0] din,
  input  logic [AW-1:0] amt,
  output logic [XW-1:0] dout
);
  logic [XW-1:0] st [0:AW];

  assign st[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH >= XW) begin : g_full
      if (LEFT) begin : g_l
        assign st[k+1] = amt[k] ? '0 : st[k];
      end else begin : g_r
        assign st[k+1] = amt[k] ? {XW{st[k][XW-1]}} : st[k];
      end
    end else begin : g_part
      if (LEFT) begin : g_l
        assign st[k+1] = amt[k] ? {st[k][XW-1-SH:0], {SH{1'b0}}} : st[k];
      end else begin : g_r
        assign st[k+1] = amt[k] ? {{SH{st[k][XW-1]}}, st[k][XW-1:SH]} : st[k];
      end
    end
  end

  assign dout = st[AW];

  always_comb begin
    if (amt == '0)
      assert_zero_amt_pass_R7 : assert (dout == din);
  end
endmodule

// File: rtl/scs_flags.sv
module scs_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  output logic              neg,
  output logic              zero
);
  assign neg  = res[DATA_W-1];
  assign zero = (res == '0);
endmodule

// File: rtl/signed_count_shifter.sv
module signed_count_shifter
  import scs_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int CNT_BITS  = DEF_CNT_BITS,
  parameter int CNT_REG_W = DEF_CNT_REG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_operand,
  input  logic [CNT_REG_W-1:0] in_count,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_result,
  output logic                 out_carry,
  output logic                 out_neg,
  output logic                 out_zero
);
  localparam int XW = DATA_W + 1;
  localparam logic [CNT_BITS-1:0] FULL = CNT_BITS'(DATA_W);

  logic unused_cnt_hi;
  assign unused_cnt_hi = ^in_count[CNT_REG_W-1:CNT_BITS];

  shift_dir_e          dir;
  logic [CNT_BITS-1:0] mag;

  scs_count_decode #(.CNT_BITS(CNT_BITS)) u_dec (
    .cnt (in_count[CNT_BITS-1:0]),
    .dir (dir),
    .mag (mag)
  );

  // Left: carry slot above bit DATA_W-1. Right: carry slot below bit 0.
  logic [XW-1:0] lft_out, rgt_out;

  scs_barrel #(.XW(XW), .AW(CNT_BITS), .LEFT(1'b1)) u_lft (
    .din  ({1'b0, in_operand}),
    .amt  (mag),
    .dout (lft_out)
  );

  scs_barrel #(.XW(XW), .AW(CNT_BITS), .LEFT(1'b0)) u_rgt (
    .din  ({in_operand, 1'b0}),
    .amt  (mag),
    .dout (rgt_out)
  );

  logic [DATA_W-1:0] nxt_res;
  logic              nxt_carry;

  always_comb begin
    unique case (dir)
      DIR_LEFT: begin
        nxt_res   = lft_out[DATA_W-1:0];
        nxt_carry = lft_out[XW-1];
      end
      DIR_RIGHT: begin
        nxt_res   = rgt_out[XW-1:1];
        nxt_carry = rgt_out[0];
      end
      default: begin
        nxt_res   = in_operand;
        nxt_carry = out_carry;
      end
    endcase
  end

  logic nxt_neg, nxt_zero;

  scs_flags #(.DATA_W(DATA_W)) u_flg (
    .res  (nxt_res),
    .neg  (nxt_neg),
    .zero (nxt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
      out_neg    <= 1'b0;
      out_zero   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nxt_res;
        out_carry  <= nxt_carry;
        out_neg    <= nxt_neg;
        out_zero   <= nxt_zero;
      end
    end
  end

  assert_valid_rise_R9 : assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R9 : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry)));
  assert_flags_R8 : assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_neg == out_result[DATA_W-1] && out_zero == (out_result == '0)));
  assert_hold_R7 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir == DIR_HOLD) |=>
      (out_result == $past(in_operand) && out_carry == $past(out_carry)));
  assert_left_sat_R6 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir == DIR_LEFT && mag >= FULL) |=> (out_result == '0));
  assert_right_sat_R6 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir == DIR_RIGHT && mag >= FULL) |=>
      (out_result == {DATA_W{$past(in_operand[DATA_W-1])}}));
  assert_left_carry_R3 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir == DIR_LEFT && mag > FULL) |=> !out_carry);
  assert_right_carry_R5 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir == DIR_RIGHT && mag >= FULL) |=>
      (out_carry == $past(in_operand[DATA_W-1])));
endmodule

// File: tb/sim_signed_count_shifter.sv
module sim_signed_count_shifter;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_operand;
  logic [31:0] in_count;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_carry, out_neg, out_zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] e_res;
  logic        e_carry;

  always #2 clk = ~clk;

  signed_count_shifter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_count(in_count), .out_valid(out_valid), .out_result(out_result),
    .out_carry(out_carry), .out_neg(out_neg), .out_zero(out_zero)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bit-at-a-time reference model.
  function automatic void model(input logic [31:0] op, input logic [31:0] cw,
                                input logic prev_c,
                                output logic [31:0] r, output logic c);
    int v;
    v = int'($signed(cw[6:0]));
    r = op;
    c = prev_c;
    if (v > 0) begin
      for (int i = 0; i < v; i++) begin
        c = r[31];
        r = {r[30:0], 1'b0};
      end
    end else if (v < 0) begin
      for (int i = 0; i < -v; i++) begin
        c = r[0];
        r = {r[31], r[31:1]};
      end
    end
  endfunction

  task automatic apply(input logic [31:0] op, input logic [31:0] cw, input string rtag);
    int v;
    string t_res, t_c;
    v = int'($signed(cw[6:0]));
    model(op, cw, e_carry, e_res, e_carry);
    if (v == 0) begin t_res = "R7"; t_c = "R7"; end
    else if (v > 0) begin t_res = (v >= 32) ? "R6" : "R2"; t_c = "R3"; end
    else begin t_res = (-v >= 32) ? "R6" : "R4"; t_c = "R5"; end
    if (rtag != "") begin t_res = rtag; t_c = rtag; end
    in_valid   = 1'b1;
    in_operand = op;
    in_count   = cw;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 valid", 32'(out_valid), 32'd1);
    chk(t_res, out_result, e_res);
    chk(t_c, 32'(out_carry), 32'(e_carry));
    chk("R8 neg", 32'(out_neg), 32'(e_res[31]));
    chk("R8 zero", 32'(out_zero), 32'(e_res == 32'd0));
  endtask

  task automatic idle();
    in_valid   = 1'b0;
    in_operand = $urandom;
    in_count   = $urandom;
    @(posedge clk);
    @(negedge clk);
    chk("R9 idle valid", 32'(out_valid), 32'd0);
    chk("R9 idle hold", out_result, e_res);
    chk("R9 idle carry", 32'(out_carry), 32'(e_carry));
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_operand = '0; in_count = '0;
    e_res = '0; e_carry = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: everything cleared by reset
    chk("R10 valid", 32'(out_valid), 32'd0);
    chk("R10 result", out_result, 32'd0);
    chk("R10 flags", {29'd0, out_carry, out_neg, out_zero}, 32'd0);
    rst = 1'b0;

    // Directed corners around the saturation edge
    apply(32'h8000_0001, 32'd1, "");          // +1
    apply(32'h8000_0001, 32'd31, "");         // +31
    apply(32'h0000_0001, 32'd32, "");         // +32 carry=op[0]=1
    apply(32'hFFFF_FFFF, 32'd33, "");         // +33 carry 0
    apply(32'hFFFF_FFFF, 32'd63, "");         // +63
    apply(32'h8000_0002, 32'h7F, "");         // -1
    apply(32'h8000_0000, 32'h61, "");         // -31
    apply(32'h7FFF_FFFF, 32'h60, "");         // -32
    apply(32'h8000_0000, 32'h5F, "");         // -33
    apply(32'h8000_0000, 32'h40, "");         // -64
    apply(32'h0000_0000, 32'h40, "");         // -64 positive operand
    // R7: zero count holds carry 1 then carry 0
    apply(32'h8000_0000, 32'd1, "");
    apply(32'h1234_5678, 32'd0, "R7");
    apply(32'h0000_0001, 32'd1, "");
    apply(32'hDEAD_BEEF, 32'd0, "R7");
    // R1: upper bits of the count word ignored
    apply(32'h8765_4321, 32'hFFFF_FF85, "R1");   // low bits +5
    apply(32'h8765_4321, 32'h0000_0F7B, "R1");   // low bits -5
    apply(32'h8765_4321, 32'hABCD_EF80, "R1");   // low bits 0
    idle();
    idle();

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] op, cw;
      op = $urandom;
      cw = $urandom;
      if ((i % 4) == 0) op = {op[31], 31'($urandom_range(0, 3))};
      if ((i % 7) == 0) cw[6:0] = 7'd0;
      if ($urandom_range(0, 4) == 0) idle();
      else apply(op, cw, "");
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule